// File: doc/BRIEF.md
# Internal Data Memory Address Router

This block sits between a small processor core and its on-chip data storage. The core presents one access per cycle: an access kind, an 8-bit address or register number, a write flag and write data, and the two bank-select bits from its status word. The router works out where that access lands and carries it out. The possible targets are a byte-wide RAM held inside the block, an external register space that occupies the upper half of the direct address map, or the stack pointer, which the block holds itself.

The upper half of the address map is where the kinds differ. A direct access to 0x80..0xFF goes to the register space. An indirect or stack access to the same address goes to the upper half of RAM. Working registers are eight bytes per bank, and the banks sit in the bottom 32 bytes of RAM. Push and pop keep the stack pointer up to date. A parameter can shrink the RAM to 128 bytes. In that case, indirect and stack accesses that fall in the upper half find no storage.

Top module: `idm_router`

## Requirements
- R1: A direct access (acc_kind 0) to 0x00..0x7F reads or writes RAM. A direct access to any other upper-half address except 0x81 is placed on the register-space port in the same cycle (sfr_addr, with sfr_we for a write or sfr_re for a read) and does not touch RAM.
- R2: An indirect access (acc_kind 1) at any address goes to RAM, so 0x80..0xFF reach the upper RAM half. Indirect, working-register and stack accesses never assert sfr_we or sfr_re.
- R3: A working-register access (acc_kind 2) uses acc_addr[2:0] as the register number n and reaches RAM address bank_sel*8 + n.
- R4: A push (acc_kind 3) first increments the stack pointer and then writes acc_wdata at the new pointer. A pop (acc_kind 4) reads at the current pointer and then decrements it. Both ignore acc_we.
- R5: After reset the stack pointer holds 0x07, so the first push writes RAM address 0x08.
- R6: Stack pointer arithmetic wraps modulo 256. A push from 0xFF writes address 0x00, and a pop from 0x00 leaves 0xFF.
- R7: A direct access to 0x81 reads or writes the stack pointer and is not placed on the register-space port. A written value takes effect on the next cycle, and the following stack accesses use it.
- R8: With RAM_BYTES = 128, indirect and stack accesses to 0x80..0xFF discard writes and read 0x00. The stack pointer still moves as in R4.
- R9: Every read returns its data on rd_data with rd_valid high exactly one cycle after the access is presented. A read is a direct, indirect or working-register access with acc_we low, or any pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 3 | 0 direct, 1 indirect, 2 working register, 3 push, 4 pop |
| acc_addr | input | 8 | Address, or register number in bits 2:0 |
| acc_we | input | 1 | Write when high (direct, indirect, working register) |
| acc_wdata | input | 8 | Write data |
| bank_sel | input | 2 | Working-register bank |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| sfr_addr | output | 8 | Register-space address |
| sfr_we | output | 1 | Register-space write strobe |
| sfr_re | output | 1 | Register-space read strobe |
| sfr_wdata | output | 8 | Register-space write data |
| sfr_rdata | input | 8 | Register-space read data, same cycle as sfr_re |

## Verification
The same upper-half address 0x90 is written directly and written indirectly with different values, then read back both ways. This shows whether the two kinds reach separate storage. Working-register writes are made in different banks and read back through direct and indirect addresses, which exposes any mistake in the bank-to-address mapping. Stack sequences are run from the reset pointer, from a pointer set to 0x7F by a direct write, and from 0xFF. Together they cover the pre-increment and post-decrement order, the upper RAM half and the wrap. A second instance built with 128 bytes of RAM is given the same stimulus, so the results of the two sizes can be compared access by access.

// File: rtl/idm_pkg.sv
package idm_pkg;

    localparam logic [2:0] KIND_DIRECT   = 3'd0;
    localparam logic [2:0] KIND_INDIRECT = 3'd1;
    localparam logic [2:0] KIND_WREG     = 3'd2;
    localparam logic [2:0] KIND_PUSH     = 3'd3;
    localparam logic [2:0] KIND_POP      = 3'd4;

    localparam logic [7:0] SP_ADDR  = 8'h81;
    localparam logic [7:0] SP_RESET = 8'h07;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_SFR,
        TGT_SP
    } tgt_e;

endpackage

// File: rtl/idm_decode.sv
module idm_decode
    import idm_pkg::*;
#(
    parameter int RAM_BYTES = 256
) (
    input  logic [2:0] kind,
    input  logic [7:0] addr,
    input  logic       we,
    input  logic [1:0] bank,
    input  logic [7:0] sp,
    output tgt_e       tgt,
    output logic [7:0] ram_addr,
    output logic [7:0] sp_after,
    output logic       is_read
);

    localparam bit UPPER_OK = (RAM_BYTES > 128);

    function automatic tgt_e ram_or_none(input logic [7:0] a);
        return (UPPER_OK || !a[7]) ? TGT_RAM : TGT_NONE;
    endfunction

    always_comb begin
        tgt      = TGT_NONE;
        ram_addr = addr;
        sp_after = sp;
        is_read  = !we;
        case (kind)
            KIND_DIRECT: begin
                if (!addr[7])
                    tgt = TGT_RAM;
                else if (addr == SP_ADDR)
                    tgt = TGT_SP;
                else
                    tgt = TGT_SFR;
            end
            KIND_INDIRECT: begin
                tgt = ram_or_none(addr);
            end
            KIND_WREG: begin
                ram_addr = {3'b000, bank, addr[2:0]};
                tgt      = TGT_RAM;
            end
            KIND_PUSH: begin
                ram_addr = sp + 8'd1;
                sp_after = sp + 8'd1;
                tgt      = ram_or_none(sp + 8'd1);
                is_read  = 1'b0;
            end
            KIND_POP: begin
                ram_addr = sp;
                sp_after = sp - 8'd1;
                tgt      = ram_or_none(sp);
                is_read  = 1'b1;
            end
            default: begin
                is_read = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
    parameter int BYTES = 256,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/idm_router.sv
module idm_router
    import idm_pkg::*;
#(
    parameter int RAM_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [2:0] acc_kind,
    input  logic [7:0] acc_addr,
    input  logic       acc_we,
    input  logic [7:0] acc_wdata,
    input  logic [1:0] bank_sel,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [7:0] sfr_addr,
    output logic       sfr_we,
    output logic       sfr_re,
    output logic [7:0] sfr_wdata,
    input  logic [7:0] sfr_rdata
);

    localparam int RAM_AW = $clog2(RAM_BYTES);

    typedef struct packed {
        logic [7:0] sp;
        logic       rvalid;
        tgt_e       src;
        logic [7:0] hold;
    } state_t;

    state_t     state_d, state_q;
    tgt_e       tgt;
    logic [7:0] ram_addr;
    logic [7:0] sp_after;
    logic       is_read;
    logic       ram_we;
    logic [7:0] ram_rdata;
    logic       unused_addr_bits;

    idm_decode #(.RAM_BYTES(RAM_BYTES)) u_decode (
        .kind     (acc_kind),
        .addr     (acc_addr),
        .we       (acc_we),
        .bank     (bank_sel),
        .sp       (state_q.sp),
        .tgt      (tgt),
        .ram_addr (ram_addr),
        .sp_after (sp_after),
        .is_read  (is_read)
    );

    idm_ram #(.BYTES(RAM_BYTES)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr[RAM_AW-1:0]),
        .wdata (acc_wdata),
        .rdata (ram_rdata)
    );

    assign unused_addr_bits = ^ram_addr;

    always_comb begin
        state_d        = state_q;
        state_d.rvalid = acc_valid && is_read;
        state_d.src    = tgt;
        case (tgt)
            TGT_SFR: state_d.hold = sfr_rdata;
            TGT_SP:  state_d.hold = state_q.sp;
            default: state_d.hold = 8'h00;
        endcase
        if (acc_valid) begin
            if (acc_kind == KIND_PUSH || acc_kind == KIND_POP)
                state_d.sp = sp_after;
            else if (tgt == TGT_SP && acc_we)
                state_d.sp = acc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sp     <= SP_RESET;
            state_q.rvalid <= 1'b0;
            state_q.src    <= TGT_NONE;
            state_q.hold   <= 8'h00;
        end else begin
            state_q <= state_d;
        end
    end

    assign ram_we    = acc_valid && (tgt == TGT_RAM) && !is_read;
    assign sfr_we    = acc_valid && (tgt == TGT_SFR) && acc_we;
    assign sfr_re    = acc_valid && (tgt == TGT_SFR) && !acc_we;
    assign sfr_addr  = acc_addr;
    assign sfr_wdata = acc_wdata;

    assign rd_valid = state_q.rvalid;
    assign rd_data  = (state_q.src == TGT_RAM) ? ram_rdata : state_q.hold;

endmodule

// File: rtl/idm_router_chk.sv
module idm_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [2:0] acc_kind,
    input logic [7:0] acc_addr,
    input logic       acc_we,
    input logic [7:0] acc_wdata,
    input logic [7:0] sp,
    input logic       rd_valid,
    input logic [7:0] sfr_addr,
    input logic       sfr_we,
    input logic       sfr_re
);

    AST_SFR_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we || sfr_re) |-> (sfr_addr[7] && sfr_addr != 8'h81)); // R1

    AST_NO_SFR_NONDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 3'd0) |-> (!sfr_we && !sfr_re)); // R2

    AST_PUSH_PREINC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 3'd3) |=> (sp == $past(sp) + 8'd1)); // R4

    AST_POP_POSTDEC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 3'd4) |=> (sp == $past(sp) - 8'd1)); // R4

    AST_SP_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp == 8'h07)); // R5

    AST_SP_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 3'd0 && acc_we && acc_addr == 8'h81)
        |=> (sp == $past(acc_wdata))); // R7

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ((acc_kind <= 3'd2 && !acc_we) || acc_kind == 3'd4))
        |=> rd_valid); // R9

endmodule

bind idm_router idm_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .sp        (state_q.sp),
    .rd_valid  (rd_valid),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_re    (sfr_re)
);

// File: tb/test_idm_router.sv
`timescale 1ns/1ps
module test_idm_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_kind = 3'd0;
    logic [7:0] acc_addr = 8'h00;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [1:0] bank_sel = 2'd0;

    logic       rd_valid, s_rd_valid;
    logic [7:0] rd_data, s_rd_data;
    logic [7:0] sfr_addr, s_sfr_addr;
    logic       sfr_we, sfr_re, s_sfr_we, s_sfr_re;
    logic [7:0] sfr_wdata, s_sfr_wdata;
    logic [7:0] sfr_rdata;

    logic [7:0] sfr_mem [128];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sfr_writes = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp_f;
        logic [7:0] exp_s;
        int         cyc;
        string      tag;
    } item_t;
    item_t expq[$];

    always #5 clk = ~clk;

    idm_router #(.RAM_BYTES(256)) i_idm_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .bank_sel(bank_sel), .rd_valid(rd_valid), .rd_data(rd_data),
        .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_re(sfr_re),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    idm_router #(.RAM_BYTES(128)) i_idm_router_small (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .bank_sel(bank_sel), .rd_valid(s_rd_valid), .rd_data(s_rd_data),
        .sfr_addr(s_sfr_addr), .sfr_we(s_sfr_we), .sfr_re(s_sfr_re),
        .sfr_wdata(s_sfr_wdata), .sfr_rdata(8'h00)
    );

    assign sfr_rdata = sfr_mem[sfr_addr[6:0]];

    initial begin
        for (int i = 0; i < 128; i++) sfr_mem[i] = 8'h00;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && sfr_we) begin
            sfr_mem[sfr_addr[6:0]] <= sfr_wdata;
            sfr_writes <= sfr_writes + 1;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_valid) begin
                if (expq.size() == 0) begin
                    check("R9 unexpected rd_valid", 8'h01, 8'h00);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    check({it.tag, " full"}, rd_data, it.exp_f);
                    check({it.tag, " small"}, s_rd_data, it.exp_s);
                    check("R9 small rd_valid", {7'd0, s_rd_valid}, 8'h01);
                    check({"R9 latency ", it.tag}, 8'(cyc - it.cyc), 8'd1);
                end
            end
        end
    end

    // Driver: present one access and push the expected read result
    task automatic acc(input logic [2:0] k, input logic [7:0] a, input logic w,
                       input logic [7:0] d, input logic [1:0] b,
                       input logic [7:0] ef, input logic [7:0] es, input string tag);
        item_t it;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_kind  = k;
        acc_addr  = a;
        acc_we    = w;
        acc_wdata = d;
        bank_sel  = b;
        if ((k <= 3'd2 && !w) || k == 3'd4) begin
            it.exp_f = ef;
            it.exp_s = es;
            it.cyc   = cyc;
            it.tag   = tag;
            expq.push_back(it);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
        acc_we    = 1'b0;
    endtask

    initial begin
        #(100000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 reset sfr_we", {7'd0, sfr_we}, 8'h00);
        rst_n = 1'b1;

        acc(0, 8'h81, 0, 0, 0, 8'h07, 8'h07, "R5 sp after reset");
        acc(3, 8'h00, 0, 8'hA1, 0, 0, 0, "push");
        acc(0, 8'h08, 0, 0, 0, 8'hA1, 8'hA1, "R4 push lands at 0x08");
        acc(2, 8'h00, 0, 0, 1, 8'hA1, 8'hA1, "R3 bank1 r0");
        acc(2, 8'h07, 1, 8'h5C, 3, 0, 0, "wr");
        acc(0, 8'h1F, 0, 0, 0, 8'h5C, 8'h5C, "R3 bank3 r7 at 0x1F");
        acc(2, 8'h05, 1, 8'h33, 2, 0, 0, "wr");
        acc(1, 8'h15, 0, 0, 0, 8'h33, 8'h33, "R3 bank2 r5 at 0x15");
        acc(0, 8'h40, 1, 8'h11, 0, 0, 0, "wr");
        acc(1, 8'h40, 0, 0, 0, 8'h11, 8'h11, "R1 direct low reaches RAM");
        acc(0, 8'h90, 1, 8'hEE, 0, 0, 0, "wr");
        acc(1, 8'h90, 1, 8'h77, 0, 0, 0, "wr");
        acc(0, 8'h90, 0, 0, 0, 8'hEE, 8'h00, "R2 direct 0x90 keeps register value");
        acc(1, 8'h90, 0, 0, 0, 8'h77, 8'h00, "R8 indirect 0x90 upper RAM");
        acc(4, 8'h00, 0, 0, 0, 8'hA1, 8'hA1, "R4 pop reads before decrement");
        acc(0, 8'h81, 0, 0, 0, 8'h07, 8'h07, "R4 sp after pop");
        acc(0, 8'h81, 1, 8'h7F, 0, 0, 0, "wr");
        acc(3, 8'h00, 0, 8'h42, 0, 0, 0, "push");
        acc(0, 8'h81, 0, 0, 0, 8'h80, 8'h80, "R7 push uses written sp");
        acc(1, 8'h80, 0, 0, 0, 8'h42, 8'h00, "R8 push into upper half");
        acc(4, 8'h00, 0, 0, 0, 8'h42, 8'h00, "R4 pop from upper half");
        acc(0, 8'h81, 0, 0, 0, 8'h7F, 8'h7F, "R7 sp after pop");
        acc(0, 8'h81, 1, 8'hFF, 0, 0, 0, "wr");
        acc(3, 8'h00, 0, 8'h99, 0, 0, 0, "push");
        acc(0, 8'h81, 0, 0, 0, 8'h00, 8'h00, "R6 sp wraps up");
        acc(0, 8'h00, 0, 0, 0, 8'h99, 8'h99, "R6 push wrote 0x00");
        acc(4, 8'h00, 0, 0, 0, 8'h99, 8'h99, "R6 pop at 0x00");
        acc(0, 8'h81, 0, 0, 0, 8'hFF, 8'hFF, "R6 sp wraps down");
        idle();
        repeat (3) @(negedge clk);

        check("R9 all reads returned", 8'(expq.size()), 8'h00);
        check("R2 one register-space write", 8'(sfr_writes), 8'h01);
        check("R7 sp not forwarded", sfr_mem[1], 8'h00);
        check("R1 register 0x90 written", sfr_mem[16], 8'hEE);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule